// File: doc/BRIEF.md
# Noise-Tolerant Peak Finder

This block watches the digitised pulse stream of one detector channel and finds the amplitude and time of each pulse maximum. Samples arrive on a data bus qualified by a valid strobe, together with the free-running timestamp of the moment each was taken. A programmable noise margin keeps small fluctuations from starting a pulse or from ending one early. A programmable confirmation count sets how many falling samples close a pulse in the stricter of two modes.

Once a maximum is confirmed, its amplitude and the timestamp of the sample that carried it are latched and a ready flag is raised. The channel then stops analysing samples until a read enable is seen. While the result is held, the block still watches for a new pulse that clearly rises above the held amplitude, and records that in a sticky overlay flag. A read releases the result, clears both flags and returns the channel to waiting.

Top module: `pkdet_top`

## Requirements
- R1: After reset, pk_ready, pk_overlay, pk_amp and pk_time are all 0, the controller is waiting for a pulse, and the reference sample is 0.
- R2: While waiting, a valid sample starts a pulse only if it is strictly greater than the reference plus noise_thr. The reference is the previous valid sample. A sample that does not clear that margin starts nothing and becomes the new reference.
- R3: In simple mode (mode_smart=0), the pulse ends on the first valid sample for which sample + noise_thr is strictly less than the running maximum. pk_ready is 1 from the following cycle.
- R4: In smart mode (mode_smart=1), the pulse ends only after confirm_cnt consecutive valid samples each satisfy sample + noise_thr < running maximum. A confirm_cnt of 0 acts as 1. A sample that lies between those bounds and does not exceed the maximum resets the count.
- R5: During a pulse, a sample strictly greater than the running maximum replaces it, records its timestamp and restarts the confirmation count.
- R6: pk_amp holds the pulse maximum. pk_time holds the ts_now value that came with the sample carrying that maximum, not the timestamp of the sample that confirmed the pulse.
- R7: While pk_ready is 1, valid samples do not change pk_amp or pk_time and do not start a new analysis.
- R8: While pk_ready is 1, a valid sample strictly greater than pk_amp + noise_thr sets pk_overlay. pk_overlay stays set until the result is read.
- R9: rd_en while pk_ready is 1 clears pk_ready and pk_overlay on the next cycle and returns the controller to waiting. rd_en has no effect when pk_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Qualifies smp_data and ts_now |
| smp_data | input | SMP_W | Unsigned sample value |
| mode_smart | input | 1 | 0 = simple mode, 1 = smart mode |
| noise_thr | input | SMP_W | Noise margin |
| confirm_cnt | input | CNT_W | Falling samples needed to confirm a pulse in smart mode |
| rd_en | input | 1 | Releases a held result |
| ts_now | input | TS_W | Timestamp that goes with the current sample |
| pk_amp | output | SMP_W | Held peak amplitude |
| pk_time | output | TS_W | Held peak timestamp |
| pk_ready | output | 1 | A result is held |
| pk_overlay | output | 1 | A further pulse arrived while the result was held |

## Verification
The bench drives samples that sit exactly at the noise margin on both sides. A design that used a non-strict comparison would start a pulse or end it one sample early. In smart mode it interleaves falling samples with a renewed rise and expects the later maximum. A counter that did not restart would report the earlier, lower peak at the wrong time. It checks that pk_time carries the maximum's timestamp rather than the confirming one, and that samples sent while a result is held leave it untouched but raise the overlay flag only when they clear the margin. A read must clear both flags.

// File: rtl/pkdet_pkg.sv
package pkdet_pkg;

  typedef enum logic [1:0] {
    PK_WAIT  = 2'd0,
    PK_TRACK = 2'd1,
    PK_HELD  = 2'd2
  } pk_state_e;

  // a exceeds b by more than margin m (evaluated one bit wider, no wrap)
  function automatic logic exceeds_by(input logic [31:0] a, input logic [31:0] b,
                                      input logic [31:0] m);
    return {1'b0, a} > ({1'b0, b} + {1'b0, m});
  endfunction

  // a lies below b by more than margin m
  function automatic logic drops_by(input logic [31:0] a, input logic [31:0] b,
                                    input logic [31:0] m);
    return ({1'b0, a} + {1'b0, m}) < {1'b0, b};
  endfunction

endpackage

// File: rtl/pkdet_events.sv
module pkdet_events #(
  parameter int SMP_W = 12
) (
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] ref_val,
  input  logic [SMP_W-1:0] held_amp,
  input  logic [SMP_W-1:0] thr,
  output logic             rise_ev,
  output logic             up_ev,
  output logic             fall_ev,
  output logic             ovl_ev
);
  import pkdet_pkg::*;

  always_comb begin
    rise_ev = exceeds_by(32'(smp), 32'(ref_val), 32'(thr));
    up_ev   = exceeds_by(32'(smp), 32'(ref_val), 32'd0);
    fall_ev = drops_by(32'(smp), 32'(ref_val), 32'(thr));
    ovl_ev  = exceeds_by(32'(smp), 32'(held_amp), 32'(thr));
  end

endmodule

// File: rtl/pkdet_ctrl.sv
module pkdet_ctrl #(
  parameter int SMP_W = 12,
  parameter int TS_W  = 14,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             mode_smart,
  input  logic [CNT_W-1:0] confirm_cnt,
  input  logic             rd_en,
  input  logic [TS_W-1:0]  ts_now,
  input  logic             rise_ev,
  input  logic             up_ev,
  input  logic             fall_ev,
  input  logic             ovl_ev,
  output logic [SMP_W-1:0] cmp_ref,
  output logic [SMP_W-1:0] pk_amp,
  output logic [TS_W-1:0]  pk_time,
  output logic             pk_ready,
  output logic             pk_overlay
);
  import pkdet_pkg::*;

  localparam int CW1 = CNT_W + 1;

  pk_state_e        state;
  logic [SMP_W-1:0] last_smp, run_max;
  logic [TS_W-1:0]  run_ts;
  logic [CNT_W-1:0] below_cnt;
  logic [CW1-1:0]   need, next_cnt;
  logic             confirm_now;
  logic             start_now, read_now;

  assign cmp_ref   = (state == PK_TRACK) ? run_max : last_smp;
  assign need      = (confirm_cnt == '0) ? CW1'(1) : {1'b0, confirm_cnt};
  assign next_cnt  = {1'b0, below_cnt} + CW1'(1);
  assign start_now = smp_valid && (state == PK_WAIT) && rise_ev;
  assign read_now  = rd_en && (state == PK_HELD);
  assign confirm_now = smp_valid && (state == PK_TRACK) && !up_ev && fall_ev &&
                       (!mode_smart || (next_cnt >= need));
  assign pk_ready  = (state == PK_HELD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PK_WAIT;
      last_smp   <= '0;
      run_max    <= '0;
      run_ts     <= '0;
      below_cnt  <= '0;
      pk_amp     <= '0;
      pk_time    <= '0;
      pk_overlay <= 1'b0;
    end else begin
      if (smp_valid) last_smp <= smp_data;
      unique case (state)
        PK_WAIT: begin
          if (start_now) begin
            state     <= PK_TRACK;
            run_max   <= smp_data;
            run_ts    <= ts_now;
            below_cnt <= '0;
          end
        end
        PK_TRACK: begin
          if (smp_valid) begin
            if (up_ev) begin
              run_max   <= smp_data;
              run_ts    <= ts_now;
              below_cnt <= '0;
            end else if (confirm_now) begin
              state     <= PK_HELD;
              pk_amp    <= run_max;
              pk_time   <= run_ts;
              below_cnt <= '0;
            end else if (fall_ev) begin
              below_cnt <= next_cnt[CNT_W-1:0];
            end else begin
              below_cnt <= '0;
            end
          end
        end
        PK_HELD: begin
          if (read_now) begin
            state      <= PK_WAIT;
            pk_overlay <= 1'b0;
          end else if (smp_valid && ovl_ev) begin
            pk_overlay <= 1'b1;
          end
        end
        default: state <= PK_WAIT;
      endcase
    end
  end

  // R7: a held result does not move until it is read
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_ready && !rd_en) |=> ($stable(pk_amp) && $stable(pk_time)));
  // R8: overlay only exists alongside a held result
  a_r8_overlay_held: assert property (@(posedge clk) disable iff (!rst_n)
    pk_overlay |-> pk_ready);
  // R9: read releases the result and clears the overlay
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_ready && rd_en) |=> (!pk_ready && !pk_overlay));
  // R3/R4: a result only appears after a sample clearing the falling margin
  a_r3_fall_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pk_ready) |-> ($past(fall_ev) && $past(smp_valid)));
  // R2: a pulse starts only on a sample clearing the rising margin
  a_r2_start_margin: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PK_WAIT && !(smp_valid && rise_ev)) |=> (state == PK_WAIT));

endmodule

// File: rtl/pkdet_top.sv
module pkdet_top #(
  parameter int SMP_W = 12,
  parameter int TS_W  = 14,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             mode_smart,
  input  logic [SMP_W-1:0] noise_thr,
  input  logic [CNT_W-1:0] confirm_cnt,
  input  logic             rd_en,
  input  logic [TS_W-1:0]  ts_now,
  output logic [SMP_W-1:0] pk_amp,
  output logic [TS_W-1:0]  pk_time,
  output logic             pk_ready,
  output logic             pk_overlay
);

  logic [SMP_W-1:0] cmp_ref;
  logic             rise_ev, up_ev, fall_ev, ovl_ev;

  pkdet_events #(.SMP_W(SMP_W)) u_events (
    .smp      (smp_data),
    .ref_val  (cmp_ref),
    .held_amp (pk_amp),
    .thr      (noise_thr),
    .rise_ev  (rise_ev),
    .up_ev    (up_ev),
    .fall_ev  (fall_ev),
    .ovl_ev   (ovl_ev)
  );

  pkdet_ctrl #(.SMP_W(SMP_W), .TS_W(TS_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .mode_smart  (mode_smart),
    .confirm_cnt (confirm_cnt),
    .rd_en       (rd_en),
    .ts_now      (ts_now),
    .rise_ev     (rise_ev),
    .up_ev       (up_ev),
    .fall_ev     (fall_ev),
    .ovl_ev      (ovl_ev),
    .cmp_ref     (cmp_ref),
    .pk_amp      (pk_amp),
    .pk_time     (pk_time),
    .pk_ready    (pk_ready),
    .pk_overlay  (pk_overlay)
  );

endmodule

// File: tb/pkdet_top_tb.sv
module pkdet_top_tb;
  localparam int SMP_W = 12, TS_W = 14, CNT_W = 4;

  logic clk = 0, rst_n = 0, smp_valid = 0, mode_smart = 0, rd_en = 0;
  logic [SMP_W-1:0] smp_data = '0, noise_thr = '0;
  logic [CNT_W-1:0] confirm_cnt = '0;
  logic [TS_W-1:0]  ts_now = '0;
  logic [SMP_W-1:0] pk_amp;
  logic [TS_W-1:0]  pk_time;
  logic             pk_ready, pk_overlay;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pkdet_top #(.SMP_W(SMP_W), .TS_W(TS_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .mode_smart(mode_smart), .noise_thr(noise_thr), .confirm_cnt(confirm_cnt),
    .rd_en(rd_en), .ts_now(ts_now), .pk_amp(pk_amp), .pk_time(pk_time),
    .pk_ready(pk_ready), .pk_overlay(pk_overlay));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one valid sample at a falling edge; returns at the next falling edge
  task automatic send(input int s, input int t);
    smp_valid = 1; smp_data = SMP_W'(s); ts_now = TS_W'(t);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic do_read();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 ready", pk_ready, 0);
    chk("R1 overlay", pk_overlay, 0);
    chk("R1 amp", pk_amp, 0);
    chk("R1 time", pk_time, 0);
  endtask

  task automatic t_noise_reject();
    mode_smart = 0; noise_thr = 10;
    send(5, 1); send(15, 2);      // 15 == 5+10: no start (R2)
    send(4, 3);                   // falling, but no pulse began
    chk("R2 no start at margin", pk_ready, 0);
    do_read();                    // rd_en with nothing held (R9)
    chk("R9 read ignored", pk_ready, 0);
  endtask

  task automatic t_simple();
    send(8, 10); send(30, 11); send(60, 12);
    send(50, 13);                 // 50+10 == 60: not a fall (R3)
    chk("R3 no end at margin", pk_ready, 0);
    send(45, 14);
    chk("R3 ready", pk_ready, 1);
    chk("R6 amp", pk_amp, 60);
    chk("R6 time is max ts", pk_time, 12);
    send(70, 15);                 // 70 == 60+10: no overlay (R8)
    chk("R8 no overlay at margin", pk_overlay, 0);
    chk("R7 amp held", pk_amp, 60);
    send(71, 16);
    chk("R8 overlay set", pk_overlay, 1);
    send(2, 17);
    chk("R8 overlay sticky", pk_overlay, 1);
    chk("R7 time held", pk_time, 12);
    do_read();
    chk("R9 ready cleared", pk_ready, 0);
    chk("R9 overlay cleared", pk_overlay, 0);
  endtask

  task automatic t_smart();
    mode_smart = 1; confirm_cnt = 3;
    send(3, 20); send(40, 21); send(80, 22);
    send(60, 23); send(65, 24);   // two below
    send(90, 25);                 // renewed rise restarts (R5)
    send(70, 26); send(50, 27);   // two below
    chk("R4 not yet confirmed", pk_ready, 0);
    send(85, 28);                 // in band: count resets (R4)
    send(60, 29); send(70, 30);
    chk("R4 band reset count", pk_ready, 0);
    send(75, 31);
    chk("R4 smart ready", pk_ready, 1);
    chk("R5 amp after rise", pk_amp, 90);
    chk("R5 time after rise", pk_time, 25);
    do_read();
    chk("R9 smart read", pk_ready, 0);
    confirm_cnt = 0;              // acts as 1
    send(2, 40); send(50, 41); send(30, 42);
    chk("R4 zero count acts as one", pk_ready, 1);
    chk("R6 zero count amp", pk_amp, 50);
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_noise_reject();
    t_simple();
    t_smart();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule